// File: doc/BRIEF.md
# Interval Interrupt Timer

This block is a down-counting interval timer that raises a single level interrupt when its count runs out. Software loads a 16-bit period one byte at a time and then writes a control byte that arms the counter and picks either a one-shot run or an auto-reloading run. The counter is loaded from the period at the arming write and then steps once per CPU-rate tick, taken from the fast clock by a built-in divider.

The block has a master enable bit in its own register. While that bit is low, writes to the control byte are dropped. Writing the bit low also flushes a pending interrupt. The interrupt is mirrored in a triggered flag that a status read returns and clears at the same time.

The state machine has three states: `TS_IDLE` (disarmed), `TS_ONCE` (armed, stops at expiry) and `TS_LOOP` (armed, reloads at expiry). Its transitions are:
- ARM_ONCE: any state to `TS_ONCE`, on an accepted control write with arm=1 and repeat=0.
- ARM_LOOP: any state to `TS_LOOP`, on an accepted control write with arm=1 and repeat=1.
- DISARM: any state to `TS_IDLE`, on an accepted control write with arm=0.
- EXPIRE_STOP: `TS_ONCE` to `TS_IDLE` at expiry.
- EXPIRE_RELOAD: `TS_LOOP` to `TS_LOOP` at expiry, with the count reloaded.

Top module: `irq_interval_timer`

## Requirements
- R1: After reset, `irq` is 0 and `status_out` is 8'h00.
- R2: The period is written as a low byte at select 0 and a high byte at select 1. An arming control write (select 2, bit 1 = 1) loads the counter from the period. A one-shot run then asserts `irq` after exactly period ticks.
- R3: One tick is DIV (default 12) clock cycles. The divider restarts at an arming write, so with period N, `irq` rises 12·N cycles after the clock edge that takes the arming write, and not earlier.
- R4: In one-shot mode (control bit 0 = 0) the timer disarms at expiry. It raises no further interrupt until it is armed again.
- R5: In repeat mode (control bit 0 = 1) the counter reloads the period at expiry and stays armed, so `irq` rises again every period ticks.
- R6: An accepted control write with bit 1 = 0 clears the triggered flag, deasserts `irq` and disarms the counter.
- R7: While the master enable (select 3, bit 0) is 0, control writes are ignored. A dropped arming write does not start the counter, either then or later when the enable is turned on.
- R8: Writing the master enable with bit 0 = 0 clears the triggered flag and deasserts `irq` on the next edge.
- R9: `status_out` returns the triggered flag in bit 0, with bits 7:1 reading 0. A status read strobe clears the flag and `irq` at the end of that cycle.
- R10: A period of 0 counts 65536 ticks before expiry.
- R11: If an expiry and a status read fall on the same edge, the expiry wins: the read returns 0 and `irq` is high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 period low, 1 period high, 2 control, 3 master enable |
| bus_wdata | input | 8 | Write data |
| stat_rd | input | 1 | Status read strobe (destructive) |
| status_out | output | 8 | Status byte, bit 0 is the triggered flag |
| irq | output | 1 | Interrupt level |

## Verification
Expiry and the destructive status read can land on the same clock edge. A bench that issues reads at random moments would almost never hit that. The bench arms a short period and counts cycles so that the read strobe is held exactly across the expiry edge. It expects the read to return 0 and `irq` to be high afterwards, and a second read then returns 1 and clears the flag. A similar collision between a disarming write and expiry is covered by giving writes priority in the counter.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_ONCE = 2'd1,
        TS_LOOP = 2'd2
    } tmr_state_e;

    localparam int CTRL_REPEAT_BIT = 0;
    localparam int CTRL_ARM_BIT    = 1;
    localparam int ENA_BIT         = 0;

endpackage

// File: rtl/irqt_regs.sv
module irqt_regs #(
    parameter int CW   = 16,
    parameter int DW   = 8,
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [SELW-1:0] sel,
    input  logic [DW-1:0]   wdata,
    output logic [CW-1:0]   period,
    output logic            ena,
    output logic            ctrl_wr,
    output logic            ctrl_arm,
    output logic            ctrl_rep,
    output logic            flush
);
    import irqt_pkg::*;

    localparam int NB       = CW / DW;
    localparam int SEL_CTRL = NB;
    localparam int SEL_ENA  = NB + 1;

    logic [DW-1:0] byte_q [NB];
    logic          ena_q;
    logic          ena_wr;

    for (genvar b = 0; b < NB; b++) begin : g_pbyte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q[b] <= '0;
            else if (wr && sel == SELW'(b))
                byte_q[b] <= wdata;
        end
        assign period[b*DW +: DW] = byte_q[b];
    end

    always_comb begin
        ena_wr   = wr && (sel == SELW'(SEL_ENA));
        ctrl_wr  = wr && (sel == SELW'(SEL_CTRL)) && ena_q;
        ctrl_arm = wdata[CTRL_ARM_BIT];
        ctrl_rep = wdata[CTRL_REPEAT_BIT];
        flush    = ena_wr && !wdata[ENA_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ena_q <= 1'b0;
        else if (ena_wr)
            ena_q <= wdata[ENA_BIT];
    end

    assign ena = ena_q;

    // R7: a control write is accepted only when the enable was already set
    a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SELW'(SEL_CTRL) && !ena_q) |-> !ctrl_wr);

endmodule

// File: rtl/irqt_prescale.sv
module irqt_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    if (DIV <= 1) begin : g_pass
        assign tick = 1'b1;
    end else begin : g_div
        localparam int PW = $clog2(DIV);
        logic [PW-1:0] pre_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pre_q <= '0;
            else if (restart || pre_q == PW'(DIV - 1))
                pre_q <= '0;
            else
                pre_q <= pre_q + 1'b1;
        end

        assign tick = (pre_q == PW'(DIV - 1));

        // R3: ticks are never back to back when dividing
        a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
    end

endmodule

// File: rtl/irqt_core.sv
module irqt_core #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ctrl_wr,
    input  logic          ctrl_arm,
    input  logic          ctrl_rep,
    input  logic [CW-1:0] period,
    output logic          fire,
    output logic          armed
);
    import irqt_pkg::*;

    tmr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d, cnt_dec;
    logic          hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and counter
    always_comb begin
        cnt_dec = cnt_q - 1'b1;
        hit     = tick && (state_q != TS_IDLE) && (cnt_dec == '0) && !ctrl_wr;
        state_d = state_q;
        cnt_d   = cnt_q;
        if (ctrl_wr) begin
            if (!ctrl_arm) begin
                state_d = TS_IDLE;                    // DISARM
            end else begin
                state_d = ctrl_rep ? TS_LOOP : TS_ONCE; // ARM_LOOP / ARM_ONCE
                cnt_d   = period;
            end
        end else begin
            unique case (state_q)
                TS_IDLE: begin
                    state_d = TS_IDLE;
                end
                TS_ONCE: begin
                    if (tick) cnt_d = cnt_dec;
                    if (hit) state_d = TS_IDLE;       // EXPIRE_STOP
                end
                TS_LOOP: begin
                    if (tick) cnt_d = hit ? period : cnt_dec; // EXPIRE_RELOAD
                end
                default: state_d = TS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        fire  = hit;
        armed = (state_q != TS_IDLE);
    end

    a_r2_arm_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_arm) |=> (cnt_q == $past(period) && state_q != TS_IDLE));

    a_r6_disarm_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_arm) |=> state_q == TS_IDLE);

    a_r4_once_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_ONCE && fire) |=> state_q == TS_IDLE);

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_LOOP && fire) |=> (state_q == TS_LOOP && cnt_q == $past(period)));

endmodule

// File: rtl/irqt_flag.sv
module irqt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic hard_clr,
    input  logic rd_clr,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hard_clr)
            flag_q <= 1'b0;
        else if (set)
            flag_q <= 1'b1;
        else if (rd_clr)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

    a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr |=> !flag_q);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !set) |=> !flag_q);

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !hard_clr) |=> flag_q);

endmodule

// File: rtl/irq_interval_timer.sv
module irq_interval_timer #(
    parameter int CW  = 16,
    parameter int DW  = 8,
    parameter int DIV = 12,
    localparam int SELW = $clog2(CW / DW + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [SELW-1:0] bus_sel,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            stat_rd,
    output logic [DW-1:0]   status_out,
    output logic            irq
);
    logic [CW-1:0] period;
    logic          ena, ctrl_wr, ctrl_arm, ctrl_rep, flush;
    logic          tick, fire, armed, flag;

    irqt_regs #(.CW(CW), .DW(DW), .SELW(SELW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(bus_sel), .wdata(bus_wdata),
        .period(period), .ena(ena), .ctrl_wr(ctrl_wr), .ctrl_arm(ctrl_arm),
        .ctrl_rep(ctrl_rep), .flush(flush)
    );

    irqt_prescale #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(ctrl_wr && ctrl_arm), .tick(tick)
    );

    irqt_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr),
        .ctrl_arm(ctrl_arm), .ctrl_rep(ctrl_rep), .period(period),
        .fire(fire), .armed(armed)
    );

    irqt_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(fire),
        .hard_clr(flush || (ctrl_wr && !ctrl_arm)),
        .rd_clr(stat_rd), .flag(flag)
    );

    assign status_out = {{(DW-1){1'b0}}, flag};
    assign irq        = flag;

    // R7: while disabled and idle, a control write cannot arm the counter
    a_r7_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena && !armed && bus_wr && bus_sel == SELW'(CW / DW)) |=> !armed);

    // R1: interrupt only comes from an expiry
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fire));

endmodule

// File: tb/irq_interval_timer_test.sv
module irq_interval_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_sel = '0;
    logic [7:0] bus_wdata = '0;
    logic       stat_rd = 1'b0;
    logic [7:0] status_out, status_one;
    logic       irq, irq_one;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    irq_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .stat_rd(stat_rd), .status_out(status_out), .irq(irq)
    );

    irq_interval_timer #(.DIV(1)) uut_one (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .stat_rd(stat_rd), .status_out(status_one), .irq(irq_one)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    // read status; the caller is at a negedge, one posedge is consumed
    task automatic rd(string req, logic [7:0] exp);
        stat_rd = 1'b1;
        #1 check(req, status_out, exp);
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 irq", irq, 0);
        check("R1 status", status_out, 8'h00);
    endtask

    task automatic t_oneshot;
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h02);
        run(35);
        check("R3 not before 12*N", irq, 0);
        run(1);
        check("R2 fires after N ticks", irq, 1);
        rd("R9 status bit0 only", 8'h01);
        check("R9 read clears irq", irq, 0);
        run(60);
        check("R4 one-shot stays quiet", irq, 0);
    endtask

    task automatic t_repeat;
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h03);
        run(23);
        check("R5 first period early", irq, 0);
        run(1);
        check("R5 first expiry", irq, 1);
        rd("R9 read in repeat", 8'h01);
        check("R9 cleared", irq, 0);
        run(22);
        check("R5 second period early", irq, 0);
        run(1);
        check("R5 reload fires again", irq, 1);
        wr(2'd2, 8'h00);
        check("R6 disarm clears irq", irq, 0);
        run(40);
        check("R6 stays disarmed", irq, 0);
    endtask

    task automatic t_ignored;
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h02);
        run(30);
        check("R7 arm ignored while disabled", irq, 0);
        check("R7 status", status_out, 8'h00);
        wr(2'd3, 8'h01);
        run(30);
        check("R7 dropped write not deferred", irq, 0);
    endtask

    task automatic t_ena_clear;
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h02);
        run(11);
        check("R3 one tick is 12 cycles", irq, 0);
        run(1);
        check("R2 period 1 fires", irq, 1);
        wr(2'd3, 8'h00);
        check("R8 enable clear drops irq", irq, 0);
        check("R8 status", status_out, 8'h00);
        wr(2'd3, 8'h01);
    endtask

    task automatic t_collision;
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h02);
        run(23);
        rd("R11 read at expiry sees 0", 8'h00);
        check("R11 expiry wins over read", irq, 1);
        rd("R11 later read sees 1", 8'h01);
        check("R11 then cleared", irq, 0);
    endtask

    task automatic t_zero;
        wr(2'd3, 8'h00);
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h02);
        run(65535);
        check("R10 zero period early", irq_one, 0);
        run(1);
        check("R10 zero period is 65536", irq_one, 1);
    endtask

    initial begin
        run(3);
        rst_n = 1'b1;
        run(2);
        t_reset();
        t_oneshot();
        t_repeat();
        t_ignored();
        t_ena_clear();
        t_collision();
        t_zero();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule